// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

This block collects device interrupt requests for a four-processor system and steers each one to the processors that want it. It keeps one shared 64-bit raw request word. Each processor has its own 64-bit enable mask and its own 64-bit pending status word. Device logic raises request bits with a post pulse and removes them with a clear pulse, each carrying a 64-bit vector. The block drives one level-sensitive device interrupt line per processor, plus a real-time-clock interrupt line that a timer sets and software acknowledges.

Software reaches the registers over a 64-bit register bus. Every request carries the size of the access and the ID of the requesting processor. A response comes back one cycle later with read data and an error flag. Unsupported indices, narrow accesses and writes to read-only words are refused with the error flag. A line stays high until every pending bit behind it has been cleared.

Top module: `irq_router_top`

## Requirements
- R1: After reset, every mask, every status word, the raw request word and the misc word are zero, and all device lines and the clock line are low.
- R2: The register index is (req_addr AND ADDR_MASK) shifted right by 6. Index 0 is control, 2 is misc, 4+n is the mask of processor n, 8+n is the status of processor n, and 12 is the raw request word. Address bits outside ADDR_MASK have no effect.
- R3: req_size encodes 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit. Any size other than 3 gives an error response and changes no state.
- R4: Every request gets rsp_valid exactly one cycle later. An unmapped index gives rsp_err with zero data, and every error response carries zero data.
- R5: A misc read returns the stored misc word with the requester's 2-bit ID ORed into bits [1:0].
- R6: A pulse on rtc_set sets misc bit 4 and raises rtc_irq. A misc write with bit 4 set clears both. A misc write with bit 4 clear is an error and changes nothing. If rtc_set arrives in the same cycle as a clearing write, the set wins.
- R7: A mask write for processor n stores the data. If the data ANDed with the raw word (after this cycle's pulses) is nonzero, the status of n becomes that AND and line n goes high.
- R8: A post pulse ORs its vector into the raw word. For each processor whose mask overlaps the vector, the whole vector is ORed into its status and its line goes high.
- R9: A clear pulse removes its bits from the raw word and from every status word. A line falls only in a cycle with a clear pulse that leaves that status word zero.
- R10: When post and clear arrive in the same cycle, the clear is applied first and the post second, so a bit in both ends up set.
- R11: The control word reads as zero. Writes to control, to any status word or to the raw word are errors and leave the state unchanged.
- R12: A mask write that has no overlap with the raw word leaves that processor's status and line as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| req_cpu | input | 2 | ID of the requesting processor |
| post_valid | input | 1 | Request-set pulse |
| post_vec | input | 64 | Bits to set |
| clr_valid | input | 1 | Request-clear pulse |
| clr_vec | input | 64 | Bits to clear |
| rtc_set | input | 1 | Timer pulse that raises the clock interrupt |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 64 | Read data |
| irq_dev | output | 4 | Device interrupt line per processor |
| rtc_irq | output | 1 | Clock interrupt line |

## Verification
On every cycle, the assertions check the response timing, the error flag on narrow accesses and the zero data on errors. They also check that posted bits land in the raw word, that cleared bits leave it, and that each line rises only after a post, a mask write or a timer pulse and falls only after a clear or an acknowledge. Only the bench's scenarios can show the data-dependent results: the exact status words after overlapping posts, the full-vector merge, the same-cycle ordering of clear, post and mask write, the address aliasing through the mask, and the misc read carrying the requester's ID.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CPU_N     = 4;
  localparam int CPU_W     = 2;
  localparam int DATA_W    = 64;
  localparam int IDX_SHIFT = 6;
  localparam logic [1:0] SZ_DWORD = 2'd3;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_MISC  = 2;
  localparam int IDX_MASK  = 4;
  localparam int IDX_STAT  = IDX_MASK + CPU_N;
  localparam int IDX_RAW   = IDX_STAT + CPU_N;
  localparam int RTC_BIT   = 4;

  typedef struct packed {
    logic             ctrl;
    logic             misc;
    logic [CPU_N-1:0] mask;
    logic [CPU_N-1:0] stat;
    logic             raw;
    logic             size_ok;
  } dec_t;
endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output dec_t              dec
);
  localparam int IDX_W = ADDR_W - IDX_SHIFT;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx         = IDX_W'((addr & ADDR_MASK) >> IDX_SHIFT);
    dec         = '0;
    dec.size_ok = (size == SZ_DWORD);
    dec.ctrl    = (idx == IDX_W'(IDX_CTRL));
    dec.misc    = (idx == IDX_W'(IDX_MISC));
    dec.raw     = (idx == IDX_W'(IDX_RAW));
    for (int n = 0; n < CPU_N; n++) begin
      dec.mask[n] = (idx == IDX_W'(IDX_MASK + n));
      dec.stat[n] = (idx == IDX_W'(IDX_STAT + n));
    end
  end
endmodule

// File: rtl/irq_router_cpu_slice.sv
module irq_router_cpu_slice #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post_v,
  input  logic [DW-1:0] post_vec,
  input  logic          clr_v,
  input  logic [DW-1:0] clr_vec,
  input  logic [DW-1:0] raw_next,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] stat_q,
  output logic          irq_q
);
  logic [DW-1:0] mask_d, stat_d, hit;
  logic          irq_d;

  // Order within one cycle: clear, then post, then mask write.
  always_comb begin
    mask_d = mask_q;
    stat_d = stat_q;
    irq_d  = irq_q;
    if (clr_v) begin
      stat_d = stat_d & ~clr_vec;
      if (stat_d == '0) irq_d = 1'b0;
    end
    if (post_v && ((post_vec & mask_q) != '0)) begin
      stat_d = stat_d | post_vec;
      irq_d  = 1'b1;
    end
    hit = mask_wdata & raw_next;
    if (mask_we) begin
      mask_d = mask_wdata;
      if (hit != '0) begin
        stat_d = hit;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/irq_router_rtc.sv
module irq_router_rtc
  import irq_router_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rtc_set,
  input  logic          misc_we,
  input  logic [DW-1:0] misc_wdata,
  output logic [DW-1:0] misc_q,
  output logic          rtc_irq,
  output logic          misc_wr_bad
);
  logic ack;

  assign ack         = misc_we &&  misc_wdata[RTC_BIT];
  assign misc_wr_bad = misc_we && !misc_wdata[RTC_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q  <= '0;
      rtc_irq <= 1'b0;
    end else begin
      if (rtc_set) begin
        misc_q[RTC_BIT] <= 1'b1;
        rtc_irq         <= 1'b1;
      end else if (ack) begin
        misc_q[RTC_BIT] <= 1'b0;
        rtc_irq         <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'h07FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic              post_valid,
  input  logic [DATA_W-1:0] post_vec,
  input  logic              clr_valid,
  input  logic [DATA_W-1:0] clr_vec,
  input  logic              rtc_set,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CPU_N-1:0]  irq_dev,
  output logic              rtc_irq
);
  dec_t              dec;
  logic              wr_ok;
  logic [DATA_W-1:0] raw_q, raw_mid, raw_next;
  logic [DATA_W-1:0] mask_q [CPU_N];
  logic [DATA_W-1:0] stat_q [CPU_N];
  logic [DATA_W-1:0] misc_q;
  logic              misc_bad;
  logic              err_c;
  logic [DATA_W-1:0] rdata_c;

  irq_router_decode #(.ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .dec  (dec)
  );

  assign wr_ok = req_valid && req_write && dec.size_ok;

  // Shared raw request word: clear first, post second.
  always_comb begin
    raw_mid  = clr_valid  ? (raw_q & ~clr_vec) : raw_q;
    raw_next = post_valid ? (raw_mid | post_vec) : raw_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_next;
  end

  for (genvar n = 0; n < CPU_N; n++) begin : g_cpu
    irq_router_cpu_slice #(.DW(DATA_W)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .post_v     (post_valid),
      .post_vec   (post_vec),
      .clr_v      (clr_valid),
      .clr_vec    (clr_vec),
      .raw_next   (raw_next),
      .mask_we    (wr_ok && dec.mask[n]),
      .mask_wdata (req_wdata),
      .mask_q     (mask_q[n]),
      .stat_q     (stat_q[n]),
      .irq_q      (irq_dev[n])
    );
  end

  irq_router_rtc #(.DW(DATA_W)) u_rtc (
    .clk         (clk),
    .rst         (rst),
    .rtc_set     (rtc_set),
    .misc_we     (wr_ok && dec.misc),
    .misc_wdata  (req_wdata),
    .misc_q      (misc_q),
    .rtc_irq     (rtc_irq),
    .misc_wr_bad (misc_bad)
  );

  // Response formation
  always_comb begin
    err_c   = 1'b0;
    rdata_c = '0;
    if (!dec.size_ok) begin
      err_c = 1'b1;
    end else if (req_write) begin
      err_c = !((dec.misc && !misc_bad) || (dec.mask != '0));
    end else begin
      err_c = !(dec.ctrl || dec.misc || dec.raw ||
                (dec.mask != '0) || (dec.stat != '0));
      if (dec.misc) rdata_c = misc_q | DATA_W'(req_cpu);
      if (dec.raw)  rdata_c = raw_q;
      for (int n = 0; n < CPU_N; n++) begin
        if (dec.mask[n]) rdata_c = mask_q[n];
        if (dec.stat[n]) rdata_c = stat_q[n];
      end
      if (err_c) rdata_c = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && err_c;
      rsp_rdata <= req_valid ? rdata_c : '0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              post_valid,
  input logic [DATA_W-1:0] post_vec,
  input logic              clr_valid,
  input logic [DATA_W-1:0] clr_vec,
  input logic              rtc_set,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [CPU_N-1:0]  irq_dev,
  input logic              rtc_irq,
  input logic [DATA_W-1:0] raw_q
);
  assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R4: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
  assert_narrow_err_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != SZ_DWORD) |=> rsp_err);
  assert_post_lands_R8: assert property (@(posedge clk) disable iff (rst)
    post_valid |=> ((raw_q & $past(post_vec)) == $past(post_vec)));
  assert_clear_removes_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !post_valid) |=> ((raw_q & $past(clr_vec)) == '0));
  assert_rtc_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rtc_irq) |-> $past(rtc_set));
  assert_rtc_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rtc_irq) |-> $past(req_valid && req_write));

  for (genvar n = 0; n < CPU_N; n++) begin : g_line
    assert_line_fall_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_dev[n]) |-> $past(clr_valid));
    assert_line_rise_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_dev[n]) |-> $past(post_valid || (req_valid && req_write)));
  end
endmodule

bind irq_router_top irq_router_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .post_valid (post_valid),
  .post_vec   (post_vec),
  .clr_valid  (clr_valid),
  .clr_vec    (clr_vec),
  .rtc_set    (rtc_set),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .irq_dev    (irq_dev),
  .rtc_irq    (rtc_irq),
  .raw_q      (raw_q)
);

// File: tb/irq_router_top_tb.sv
`timescale 1ns/1ps
module irq_router_top_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_POST = 2'd2, OP_CLR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  cpu;
    logic [4:0]  idx;
    logic [63:0] data;
    logic [63:0] exp;
    logic        err;
    logic [3:0]  irq;
    logic [7:0]  rq;
  } vec_t;

  // Indices: 0 ctrl, 1 unmapped, 2 misc, 4+n mask, 8+n status, 12 raw.
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{OP_WR,   2'd0, 5'd4,  64'h0F,  64'h0,   1'b0, 4'b0000, 8'd7},  // R7 no raw yet
    '{OP_POST, 2'd0, 5'd0,  64'h05,  64'h0,   1'b0, 4'b0001, 8'd8},  // R8
    '{OP_RD,   2'd0, 5'd8,  64'h0,   64'h05,  1'b0, 4'b0001, 8'd8},
    '{OP_RD,   2'd0, 5'd12, 64'h0,   64'h05,  1'b0, 4'b0001, 8'd8},
    '{OP_WR,   2'd1, 5'd5,  64'h100, 64'h0,   1'b0, 4'b0001, 8'd12}, // R12
    '{OP_POST, 2'd0, 5'd0,  64'h300, 64'h0,   1'b0, 4'b0011, 8'd8},
    '{OP_RD,   2'd2, 5'd9,  64'h0,   64'h300, 1'b0, 4'b0011, 8'd8},  // whole vector
    '{OP_CLR,  2'd0, 5'd0,  64'h004, 64'h0,   1'b0, 4'b0011, 8'd9},  // R9 partial
    '{OP_CLR,  2'd0, 5'd0,  64'h001, 64'h0,   1'b0, 4'b0010, 8'd9},
    '{OP_WR,   2'd0, 5'd6,  64'h200, 64'h0,   1'b0, 4'b0110, 8'd7},
    '{OP_RD,   2'd0, 5'd10, 64'h0,   64'h200, 1'b0, 4'b0110, 8'd7},
    '{OP_RD,   2'd3, 5'd2,  64'h0,   64'h3,   1'b0, 4'b0110, 8'd5},  // R5
    '{OP_RD,   2'd0, 5'd0,  64'h0,   64'h0,   1'b0, 4'b0110, 8'd11}, // R11
    '{OP_WR,   2'd0, 5'd8,  64'hFF,  64'h0,   1'b1, 4'b0110, 8'd11},
    '{OP_WR,   2'd0, 5'd12, 64'hFF,  64'h0,   1'b1, 4'b0110, 8'd11},
    '{OP_RD,   2'd0, 5'd8,  64'h0,   64'h0,   1'b0, 4'b0110, 8'd11},
    '{OP_RD,   2'd0, 5'd12, 64'h0,   64'h300, 1'b0, 4'b0110, 8'd11},
    '{OP_RD,   2'd0, 5'd1,  64'h0,   64'h0,   1'b1, 4'b0110, 8'd4},  // R4
    '{OP_CLR,  2'd0, 5'd0,  64'h300, 64'h0,   1'b0, 4'b0000, 8'd9},
    '{OP_RD,   2'd0, 5'd5,  64'h0,   64'h100, 1'b0, 4'b0000, 8'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_size = 2'd3;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_cpu = '0;
  logic        post_valid = 0, clr_valid = 0, rtc_set = 0;
  logic [63:0] post_vec = '0, clr_vec = '0;
  logic        rsp_valid, rsp_err, rtc_irq;
  logic [63:0] rsp_rdata;
  logic [3:0]  irq_dev;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_router_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .post_valid(post_valid), .post_vec(post_vec),
    .clr_valid(clr_valid), .clr_vec(clr_vec), .rtc_set(rtc_set),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_dev(irq_dev), .rtc_irq(rtc_irq)
  );

  function automatic logic [15:0] at(input int idx);
    return 16'(idx) << 6;
  endfunction

  task automatic chk(input int rq, input string what, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  // One cycle of stimulus; outputs are sampled at the following falling edge.
  task automatic step(input logic v, input logic w, input logic [1:0] sz,
                      input logic [15:0] a, input logic [63:0] d, input logic [1:0] c,
                      input logic pv, input logic [63:0] pvec,
                      input logic cv, input logic [63:0] cvec, input logic rs);
    @(negedge clk);
    req_valid = v; req_write = w; req_size = sz; req_addr = a;
    req_wdata = d; req_cpu = c; post_valid = pv; post_vec = pvec;
    clr_valid = cv; clr_vec = cvec; rtc_set = rs;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_size = 2'd3; post_valid = 0;
    clr_valid = 0; rtc_set = 0; post_vec = '0; clr_vec = '0;
  endtask

  task automatic rd(input int rq, input string what, input int idx, input logic [1:0] c, input logic [63:0] exp);
    step(1, 0, 2'd3, at(idx), '0, c, 0, '0, 0, '0, 0);
    chk(rq, {what, " valid"}, 64'(rsp_valid), 64'd1);
    chk(rq, {what, " data"}, rsp_rdata, exp);
  endtask

  task automatic wr(input int rq, input string what, input int idx, input logic [63:0] d, input logic exp_err);
    step(1, 1, 2'd3, at(idx), d, 2'd0, 0, '0, 0, '0, 0);
    chk(rq, {what, " err"}, 64'(rsp_err), 64'(exp_err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(1, "irq lines after reset", 64'(irq_dev), 64'h0);
    chk(1, "rtc line after reset", 64'(rtc_irq), 64'h0);
    rd(1, "raw after reset", 12, 2'd0, 64'h0);
    rd(1, "mask0 after reset", 4, 2'd0, 64'h0);
    rd(1, "misc after reset", 2, 2'd0, 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = TBL[i];
      case (t.op)
        OP_WR:   step(1, 1, 2'd3, at(int'(t.idx)), t.data, t.cpu, 0, '0, 0, '0, 0);
        OP_RD:   step(1, 0, 2'd3, at(int'(t.idx)), '0, t.cpu, 0, '0, 0, '0, 0);
        OP_POST: step(0, 0, 2'd3, '0, '0, 2'd0, 1, t.data, 0, '0, 0);
        default: step(0, 0, 2'd3, '0, '0, 2'd0, 0, '0, 1, t.data, 0);
      endcase
      chk(int'(t.rq), $sformatf("row %0d lines", i), 64'(irq_dev), 64'(t.irq));
      if (t.op == OP_WR || t.op == OP_RD) begin
        chk(int'(t.rq), $sformatf("row %0d err", i), 64'(rsp_err), 64'(t.err));
        if (t.op == OP_RD)
          chk(int'(t.rq), $sformatf("row %0d data", i), rsp_rdata, t.exp);
      end
    end

    // R3 narrow accesses refused, state untouched
    step(1, 1, 2'd2, at(7), 64'hFF, 2'd0, 0, '0, 0, '0, 0);
    chk(3, "32-bit write err", 64'(rsp_err), 64'd1);
    rd(3, "mask3 after narrow write", 7, 2'd0, 64'h0);
    step(1, 0, 2'd0, at(4), '0, 2'd0, 0, '0, 0, '0, 0);
    chk(3, "8-bit read err", 64'(rsp_err), 64'd1);
    chk(3, "8-bit read data", rsp_rdata, 64'h0);

    // R2 bits outside the address mask and low offset bits ignored
    step(1, 1, 2'd3, 16'h8000 | at(7) | 16'h002A, 64'h1, 2'd0, 0, '0, 0, '0, 0);
    chk(2, "aliased write err", 64'(rsp_err), 64'd0);
    rd(2, "mask3 via alias", 7, 2'd0, 64'h1);

    // R10 same-cycle clear and post of one bit: bit ends set
    step(0, 0, 2'd3, '0, '0, 2'd0, 1, 64'h1, 1, 64'h1, 0);
    chk(10, "lines after post+clear", 64'(irq_dev), 64'b1001);
    rd(10, "raw after post+clear", 12, 2'd0, 64'h1);

    // R7 mask write sees the post of the same cycle
    step(1, 1, 2'd3, at(5), 64'h40, 2'd0, 1, 64'h40, 0, '0, 0);
    chk(7, "lines after mask+post", 64'(irq_dev), 64'b1011);
    rd(7, "stat1 after mask+post", 9, 2'd0, 64'h40);

    // R12 non-overlapping mask write keeps status and line
    wr(12, "mask0 no overlap", 4, 64'h800, 1'b0);
    chk(12, "line0 kept", 64'(irq_dev), 64'b1011);
    rd(12, "stat0 kept", 8, 2'd0, 64'h1);

    // R9 clear drops lines whose status empties
    step(0, 0, 2'd3, '0, '0, 2'd0, 0, '0, 1, 64'h1, 0);
    chk(9, "lines after clear", 64'(irq_dev), 64'b0010);

    // R6 clock interrupt set and acknowledge
    step(0, 0, 2'd3, '0, '0, 2'd0, 0, '0, 0, '0, 1);
    chk(6, "rtc set", 64'(rtc_irq), 64'd1);
    rd(6, "misc with id", 2, 2'd1, 64'h11);
    wr(6, "misc write bit4 clear", 2, 64'h1, 1'b1);
    chk(6, "rtc kept after bad write", 64'(rtc_irq), 64'd1);
    step(1, 1, 2'd3, at(2), 64'h10, 2'd0, 0, '0, 0, '0, 1);
    chk(6, "set wins over ack", 64'(rtc_irq), 64'd1);
    wr(6, "misc ack", 2, 64'h10, 1'b0);
    chk(6, "rtc cleared", 64'(rtc_irq), 64'd0);
    rd(5, "misc after ack", 2, 2'd2, 64'h2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule